// File: doc/BRIEF.md
# Soft Reset and Clock Gate Control Register

This block is the reset and clock control register of a peripheral. It holds one soft-reset flag in the top bit, one clock-gate flag in the bit below it, and a field of ordinary control bits underneath. Software reaches it through a plain register port: a write enable, a byte address, write data and read data. Three offsets decode to the same register. A write at offset 0x0 loads the whole word. A write at offset 0x4 turns on each bit that is one in the data. A write at offset 0x8 turns off each bit that is one in the data.

The soft-reset flag drives a reset output into the peripheral's logic. While that flag is high and the clock is running, the control field is held at zero. The flag also takes a fixed settle time, counted in clock cycles. When that time is up, the hardware raises the clock-gate flag by itself, so a driver can poll for that bit to confirm the reset took effect. The clock-gate flag stops the peripheral's functional clock enable, and while it is set the control field cannot change. A light-weight bring-up that only clears both flags, without ever pulsing soft reset, leaves the block running and never leaves it stuck.

Top module: `srcg_ctrl`

## Requirements
- R1: After power-on reset the register reads 0xC000_0000: soft reset (bit 31) and clock gate (bit 30) are both set and bits 29:0 are zero. `clk_en` is low and `blk_rst` is high.
- R2: A write at offset 0x0 replaces the register with the write data, provided the clock gate is clear.
- R3: A write at offset 0x4 sets each register bit that is one in the write data and leaves the other bits as they were.
- R4: A write at offset 0x8 clears each register bit that is one in the write data and leaves the other bits as they were.
- R5: `rd_data` always shows the current register value, whatever the address.
- R6: A write at any offset other than 0x0, 0x4 and 0x8 leaves the register unchanged.
- R7: `clk_en` is high exactly when the clock-gate bit (bit 30) is clear.
- R8: While the clock-gate bit is set, bits 29:0 keep their value under every kind of write. Bits 31 and 30 can still be written.
- R9: `blk_rst` follows the soft-reset bit (bit 31). While soft reset is set and the clock gate is clear, bits 29:0 become zero on the next clock edge.
- R10: When soft reset has been set and stays set, the hardware sets the clock-gate bit on the SETTLE_CYCLES-th clock edge after the write edge (the third edge at the default). This hardware set wins over a clear of the gate written on that same edge. It happens only once each time soft reset is asserted.
- R11: In the enable-only sequence, soft reset is cleared and then the clock gate is cleared, and soft reset is never set. Both bits then stay clear and `clk_en` stays high.
- R12: In the full bring-up order the gate goes high SETTLE_CYCLES edges after soft reset is set. The order is: clear soft reset, clear gate, set soft reset, poll the gate high, clear soft reset, clear gate. The block ends with both flags clear and `clk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (4) | Byte offset: 0x0 load, 0x4 set bits, 0x8 clear bits |
| wr_data | input | DATA_W (32) | Write data or bit mask |
| rd_data | output | DATA_W (32) | Current register value |
| clk_en | output | 1 | Functional clock enable, low while gated |
| blk_rst | output | 1 | Reset into the peripheral's logic, high while soft reset is set |

## Verification
The bench builds the block with its defaults: a 32-bit register, a 4-bit offset and a settle count of 3. The count is small enough that each edge of the soft-reset settle window can be checked on its own. With these values, the bench can land a gate-clear write on exactly the edge where the hardware sets the gate, and it can measure the polled wait in the bring-up sequence against the expected three cycles. The 4-bit offset also leaves room for unused offsets such as 0x2 and 0xC, which the bench uses to show that writes there are ignored.

// File: rtl/srcg_ctrl.sv
module srcg_ctrl #(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_en,
  output logic              blk_rst
);
  localparam int SRST_BIT = DATA_W - 1;
  localparam int GATE_BIT = DATA_W - 2;
  localparam int CW       = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFF_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8);
  localparam logic [CW-1:0]     FIRE_AT  = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0]     SAT      = CW'(SETTLE_CYCLES);
  localparam logic [DATA_W-1:0] RST_VAL  = {2'b11, {(DATA_W-2){1'b0}}};

  logic [DATA_W-1:0] ctl, wr_val, nxt;
  logic [CW-1:0]     cnt;
  logic              hit, srst, gate, hw_fire;

  assign srst    = ctl[SRST_BIT];
  assign gate    = ctl[GATE_BIT];
  assign hw_fire = srst && (cnt == FIRE_AT);

  always_comb begin
    hit    = wr_en;
    wr_val = ctl;
    unique case (addr)
      OFF_LOAD: wr_val = wr_data;
      OFF_SET:  wr_val = ctl | wr_data;
      OFF_CLR:  wr_val = ctl & ~wr_data;
      default:  hit    = 1'b0;
    endcase
  end

  always_comb begin
    nxt = hit ? wr_val : ctl;
    if (gate)
      nxt[GATE_BIT-1:0] = ctl[GATE_BIT-1:0];
    else if (srst)
      nxt[GATE_BIT-1:0] = '0;
    if (hw_fire)
      nxt[GATE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= RST_VAL;
      cnt <= '0;
    end else begin
      ctl <= nxt;
      if (!srst)
        cnt <= '0;
      else if (cnt < SAT)
        cnt <= cnt + 1'b1;
    end
  end

  assign rd_data = ctl;
  assign clk_en  = ~gate;
  assign blk_rst = srst;

  assert_low_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> $stable(ctl[GATE_BIT-1:0]));

  assert_gate_rise_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[GATE_BIT]) |-> ($past(wr_en) || $past(srst)));

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> (cnt == '0));

  assert_srst_zeroes_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !gate) |=> (ctl[GATE_BIT-1:0] == '0));

  assert_bad_offset_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit && !srst && !gate) |=> $stable(ctl));

  assert_clk_en_tracks_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> ($past(wr_en) || $past(srst)));
endmodule

// File: tb/srcg_ctrl_bench.sv
module srcg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_en, blk_rst;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srcg_ctrl u_srcg_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en), .blk_rst(blk_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 value", rd_data, 32'hC000_0000);
    chk("R1 clk_en", {31'd0, clk_en}, 32'd0);
    chk("R1 blk_rst", {31'd0, blk_rst}, 32'd1);
  endtask

  task automatic t_enable_only();
    wr(4'h8, 32'h8000_0000);
    chk("R11 srst cleared", rd_data, 32'h4000_0000);
    chk("R9 blk_rst low", {31'd0, blk_rst}, 32'd0);
    wr(4'h8, 32'h4000_0000);
    chk("R11 gate cleared", rd_data, 32'h0);
    repeat (10) @(negedge clk);
    chk("R11 stays clear", rd_data, 32'h0);
    chk("R11 R7 clk_en high", {31'd0, clk_en}, 32'd1);
  endtask

  task automatic t_access();
    wr(4'h0, 32'h0000_1234);
    chk("R2 load", rd_data, 32'h0000_1234);
    wr(4'h0, 32'h0000_00A5);
    chk("R2 reload", rd_data, 32'h0000_00A5);
    wr(4'h4, 32'h0000_0F00);
    chk("R3 set alias", rd_data, 32'h0000_0FA5);
    wr(4'h8, 32'h0000_0005);
    chk("R4 clear alias", rd_data, 32'h0000_0FA0);
    for (int i = 0; i < 4; i++) begin
      addr = 4'(i * 4);
      #1;
      chk("R5 read any offset", rd_data, 32'h0000_0FA0);
    end
    addr = '0;
    wr(4'hC, 32'hFFFF_FFFF);
    chk("R6 offset 0xC ignored", rd_data, 32'h0000_0FA0);
    wr(4'h2, 32'hFFFF_FFFF);
    chk("R6 offset 0x2 ignored", rd_data, 32'h0000_0FA0);
    chk("R6 clk_en kept", {31'd0, clk_en}, 32'd1);
  endtask

  task automatic t_freeze();
    wr(4'h4, 32'h4000_0000);
    chk("R7 gate set", rd_data, 32'h4000_0FA0);
    chk("R7 clk_en low", {31'd0, clk_en}, 32'd0);
    wr(4'h0, 32'h4000_FFFF);
    chk("R8 load frozen", rd_data, 32'h4000_0FA0);
    wr(4'h4, 32'h0000_000F);
    chk("R8 set frozen", rd_data, 32'h4000_0FA0);
    wr(4'h8, 32'h4000_0000);
    chk("R8 gate still writable", rd_data, 32'h0000_0FA0);
    chk("R7 clk_en back high", {31'd0, clk_en}, 32'd1);
  endtask

  task automatic t_soft_reset();
    wr(4'h4, 32'h8000_0000);
    chk("R9 srst set", rd_data, 32'h8000_0FA0);
    chk("R9 blk_rst high", {31'd0, blk_rst}, 32'd1);
    @(negedge clk);
    chk("R9 low bits zeroed / R10 edge1", rd_data, 32'h8000_0000);
    @(negedge clk);
    chk("R10 edge2 no gate", rd_data, 32'h8000_0000);
    @(negedge clk);
    chk("R10 edge3 gate set", rd_data, 32'hC000_0000);
    wr(4'h8, 32'h4000_0000);
    chk("R10 gate cleared by sw", rd_data, 32'h8000_0000);
    repeat (5) @(negedge clk);
    chk("R10 set only once", rd_data, 32'h8000_0000);
    wr(4'h8, 32'h8000_0000);
    chk("R9 srst released", rd_data, 32'h0);
    wr(4'h4, 32'h8000_0000);
    @(negedge clk);
    @(negedge clk);
    wr(4'h8, 32'h4000_0000);
    chk("R10 hw set wins over clear", rd_data, 32'hC000_0000);
  endtask

  task automatic t_bringup();
    int n;
    wr(4'h8, 32'h8000_0000);
    chk("R12 clear srst", rd_data, 32'h4000_0000);
    wr(4'h8, 32'h4000_0000);
    chk("R12 clear gate", rd_data, 32'h0);
    wr(4'h4, 32'h8000_0000);
    n = 0;
    while (!rd_data[30] && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R12 poll cycles", 32'(n), 32'd3);
    wr(4'h8, 32'h8000_0000);
    wr(4'h8, 32'h4000_0000);
    chk("R12 final value", rd_data, 32'h0);
    chk("R12 clk_en high", {31'd0, clk_en}, 32'd1);
    chk("R12 blk_rst low", {31'd0, blk_rst}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_enable_only();
    t_access();
    t_freeze();
    t_soft_reset();
    t_bringup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule